// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Controller

This block lets a processor read an external serial flash as if it were ordinary memory. It sits between a simple system-bus read port and the serial frame sequencer. When no frame is open, a bus read starts a serial command frame at that read's address. While the reads stay sequential, data keeps streaming from the open frame. A read that breaks the sequence throws away whatever was buffered and starts a new frame at its own address.

Bytes from the sequencer go into a small buffer. This lets the serial stream and the bus accesses run at different sizes. Each byte, halfword or word read is packed little-endian from the head of the buffer.

A second, non-memory mode is for register-style serial commands. In this mode only the first access of a frame sets the address. Each later access transfers exactly as many serial bytes as its own size. In both modes, software closes the open frame with a last-transfer command, and a frame-done flag then rises.

Top module: `flash_rd_ctrl`

## Requirements
- R1: After reset, `bus_ready`, `rx_ready`, `frame_start`, `frame_close` and `frame_done` are all low.
- R2: In memory mode, a read accepted while no frame is open pulses `frame_start` for one cycle, on the cycle after the read is first seen. During that pulse, `frame_addr` equals the read's address.
- R3: In memory mode, a read is sequential when its address equals the previous read's address plus that read's byte count. A sequential read starts no new frame and takes its data from the continuing stream.
- R4: In memory mode, a read that is not sequential starts a new frame at its own address. All bytes buffered from the old frame are discarded, so the returned data comes from the new address.
- R5: `bus_size` selects the access width: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. The byte from the lowest flash address goes in `bus_rdata[7:0]`, each following byte goes in the next-higher lane, and unused lanes read as zero.
- R6: `bus_ready` rises only once enough serial bytes for the whole access have been buffered. It stays low while the serial stream is stalled. It is never high during a `frame_start` pulse.
- R7: In memory mode, the open frame prefetches serial bytes until the buffer holds BUF_DEPTH bytes. It then holds `rx_ready` low.
- R8: In non-memory mode, only the first access of a frame sets the frame address. Later accesses at any address continue the same serial stream.
- R9: In non-memory mode, each access takes in exactly as many serial bytes as its size. `rx_ready` is low whenever no access is pending.
- R10: A `last_xfer` pulse while idle with a frame open pulses `frame_close` and sets `frame_done` on the next cycle. The next read then starts a new frame even if it is sequential. `frame_done` clears when a frame starts.
- R11: A `last_xfer` pulse while a bus read is waiting for data has no effect. No `frame_close` pulse is produced, and the pending read completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_mode | input | 1 | 1: memory read mode, 0: non-memory transfer mode |
| bus_req | input | 1 | Read request, held until `bus_ready` |
| bus_addr | input | ADDR_W | Read byte address |
| bus_size | input | 2 | Access size code |
| bus_ready | output | 1 | Read data valid, handshake completes |
| bus_rdata | output | 32 | Read data, little-endian packed |
| last_xfer | input | 1 | Software command closing the open frame |
| frame_start | output | 1 | One-cycle pulse: send a new command frame |
| frame_close | output | 1 | One-cycle pulse: end the open frame |
| frame_addr | output | ADDR_W | Address of the frame being started |
| frame_done | output | 1 | Set when a frame is closed, cleared at frame start |
| rx_valid | input | 1 | Serial byte valid from the sequencer |
| rx_byte | input | 8 | Serial byte |
| rx_ready | output | 1 | Controller accepts a serial byte |

## Verification
The bench builds the controller with BUF_DEPTH=4, the smallest depth that can still hold a word. With this depth a word read drains the whole buffer, the read pointer wraps every few bytes, and the full-buffer stall of the prefetch is reached within a few cycles of idling. ADDR_W=16 keeps random addresses in a range where sequential runs and jumps are both frequent. Random throttling of the serial stream exposes the ready timing against partially filled buffers.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } ctl_state_e;

    localparam int unsigned LANES = 4;

    // Byte count of an access size code; code 3 aliases a word.
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        logic [2:0] n;
        case (sz)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/flash_rd_buf.sv
module flash_rd_buf #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LANES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          push,
    input  logic [7:0]                    push_byte,
    input  logic                          pop,
    input  logic [2:0]                    pop_n,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic [LANES-1:0][7:0]         peek
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } buf_st_t;

    buf_st_t           q, d;
    logic [7:0]        mem [DEPTH];

    always_comb begin
        d = q;
        if (flush) begin
            d.wr  = '0;
            d.rd  = '0;
            d.cnt = '0;
        end else begin
            if (push) begin
                d.wr = q.wr + PW'(1);
            end
            if (pop) begin
                d.rd = q.rd + PW'(pop_n);
            end
            d.cnt = q.cnt + CW'(push) - (pop ? CW'(pop_n) : CW'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[q.wr] <= push_byte;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_peek
        assign peek[k] = mem[q.rd + PW'(k)];
    end

    assign level = q.cnt;

endmodule

// File: rtl/flash_rd_pack.sv
module flash_rd_pack
    import flash_rd_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  logic [1:0]             size,
    input  logic [LANES-1:0][7:0]  bytes_in,
    output logic [LANES*8-1:0]     word_out
);
    logic [2:0] nb;
    assign nb = size_bytes(size);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word_out[k*8 +: 8] = (3'(k) < nb) ? bytes_in[k] : 8'h00;
    end

endmodule

// File: rtl/flash_rd_ctrl.sv
module flash_rd_ctrl
    import flash_rd_pkg::*;
#(
    parameter int unsigned ADDR_W    = 24,
    parameter int unsigned BUF_DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mem_mode,
    input  logic               bus_req,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [1:0]         bus_size,
    output logic               bus_ready,
    output logic [31:0]        bus_rdata,
    input  logic               last_xfer,
    output logic               frame_start,
    output logic               frame_close,
    output logic [ADDR_W-1:0]  frame_addr,
    output logic               frame_done,
    input  logic               rx_valid,
    input  logic [7:0]         rx_byte,
    output logic               rx_ready
);
    localparam int unsigned CW = $clog2(BUF_DEPTH + 1);

    typedef struct packed {
        ctl_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        size;
        logic [ADDR_W-1:0] next_addr;
        logic              open;
        logic              start;
        logic              close;
        logic              done;
        logic [ADDR_W-1:0] faddr;
    } ctl_st_t;

    ctl_st_t               q, d;
    logic                  flush;
    logic                  restart;
    logic                  enough;
    logic [2:0]            need;
    logic [CW-1:0]         level;
    logic [LANES-1:0][7:0] peek;
    logic                  accept_rx;
    logic                  take;

    assign need   = size_bytes(q.size);
    assign enough = (q.state == ST_DATA) && (level >= CW'(need));
    assign take   = enough;

    always_comb begin
        if (mem_mode) begin
            rx_ready = q.open && (level < CW'(BUF_DEPTH));
        end else begin
            rx_ready = (q.state == ST_DATA) && (level < CW'(need));
        end
    end

    assign accept_rx = rx_valid && rx_ready;

    always_comb begin
        d         = q;
        d.start   = 1'b0;
        d.close   = 1'b0;
        flush     = 1'b0;
        restart   = !q.open || (mem_mode && (bus_addr != q.next_addr));
        case (q.state)
            ST_IDLE: begin
                if (last_xfer) begin
                    if (q.open) begin
                        d.close = 1'b1;
                        d.open  = 1'b0;
                        d.done  = 1'b1;
                        flush   = 1'b1;
                    end
                end else if (bus_req) begin
                    d.addr  = bus_addr;
                    d.size  = bus_size;
                    d.state = ST_DATA;
                    if (restart) begin
                        d.start = 1'b1;
                        d.faddr = bus_addr;
                        d.open  = 1'b1;
                        d.done  = 1'b0;
                        flush   = 1'b1;
                    end
                end
            end
            default: begin
                if (take) begin
                    d.state     = ST_IDLE;
                    d.next_addr = q.addr + ADDR_W'(need);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    flash_rd_buf #(
        .DEPTH (BUF_DEPTH),
        .LANES (LANES)
    ) i_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (accept_rx),
        .push_byte (rx_byte),
        .pop       (take),
        .pop_n     (need),
        .level     (level),
        .peek      (peek)
    );

    flash_rd_pack #(
        .LANES (LANES)
    ) i_pack (
        .size     (q.size),
        .bytes_in (peek),
        .word_out (bus_rdata)
    );

    assign bus_ready   = enough;
    assign frame_start = q.start;
    assign frame_close = q.close;
    assign frame_addr  = q.faddr;
    assign frame_done  = q.done;

endmodule

// File: rtl/flash_rd_ctrl_chk.sv
module flash_rd_ctrl_chk #(
    parameter int unsigned ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_mode,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ready,
    input logic              frame_start,
    input logic              frame_close,
    input logic [ADDR_W-1:0] frame_addr,
    input logic              frame_done,
    input logic              rx_ready
);

    p_start_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (frame_addr == $past(bus_addr)))
        else $error("frame address differs from the triggering read");

    p_start_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !bus_ready)
        else $error("data offered in the cycle a frame starts");

    p_start_close_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_start, frame_close}))
        else $error("frame start and close together");

    p_close_sets_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_close |-> frame_done)
        else $error("close without done flag");

    p_start_clears_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !frame_done)
        else $error("done flag still set at frame start");

    p_nonmem_idle_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_mode && !bus_req) |-> !rx_ready)
        else $error("serial bytes taken with no access pending");

endmodule

bind flash_rd_ctrl flash_rd_ctrl_chk #(
    .ADDR_W (ADDR_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_mode    (mem_mode),
    .bus_req     (bus_req),
    .bus_addr    (bus_addr),
    .bus_ready   (bus_ready),
    .frame_start (frame_start),
    .frame_close (frame_close),
    .frame_addr  (frame_addr),
    .frame_done  (frame_done),
    .rx_ready    (rx_ready)
);

// File: tb/test_flash_rd_ctrl.sv
module test_flash_rd_ctrl;
    localparam int unsigned AW    = 16;
    localparam int unsigned DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mem_mode = 1'b1;
    logic          bus_req = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic          bus_ready;
    logic [31:0]   bus_rdata;
    logic          last_xfer = 1'b0;
    logic          frame_start, frame_close, frame_done;
    logic [AW-1:0] frame_addr;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_byte = '0;
    logic          rx_ready;

    int n_run = 0, n_fail = 0;
    int fs_cnt = 0, fc_cnt = 0, acc = 0, tot_acc = 0;
    int rx_prob = 100;
    bit rx_en = 1'b1;
    bit s_act = 1'b0;
    logic [AW-1:0] s_ptr = '0;

    bit            m_open = 1'b0;
    logic [AW-1:0] m_next = '0;
    logic [AW-1:0] m_ptr  = '0;

    always #4 clk = ~clk;

    flash_rd_ctrl #(.ADDR_W(AW), .BUF_DEPTH(DEPTH)) i_flash_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .mem_mode(mem_mode), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .last_xfer(last_xfer), .frame_start(frame_start),
        .frame_close(frame_close), .frame_addr(frame_addr), .frame_done(frame_done),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready)
    );

    function automatic logic [7:0] fbyte(input logic [AW-1:0] a);
        return a[7:0] * 8'd37 + a[15:8] * 8'd11 + 8'h5A;
    endfunction

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] pack(input logic [AW-1:0] a, input logic [1:0] sz);
        logic [31:0] w = '0;
        for (int k = 0; k < nbytes(sz); k++) w[k*8 +: 8] = fbyte(a + AW'(k));
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Flash / sequencer model, acts on falling edges only.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (frame_start) begin
                    s_ptr = frame_addr; s_act = 1'b1; acc = 0; fs_cnt++;
                end
                if (frame_close) begin
                    s_act = 1'b0; fc_cnt++;
                end
                rx_valid = s_act && rx_en && (($urandom % 100) < rx_prob);
                rx_byte  = fbyte(s_ptr);
                if (rx_valid && rx_ready) begin
                    s_ptr++; acc++; tot_acc++;
                end
            end
        end
    end

    // One bus read with full checking against the model.
    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz, input string req);
        int fs0, ac0, n;
        bit exp_rs;
        logic [31:0] exp_d;
        n = nbytes(sz);
        exp_rs = !m_open || (mem_mode && (a != m_next));
        if (exp_rs) begin
            m_open = 1'b1; m_ptr = a;
        end
        exp_d = mem_mode ? pack(a, sz) : pack(m_ptr, sz);
        @(negedge clk);
        fs0 = fs_cnt; ac0 = tot_acc;
        bus_req = 1'b1; bus_addr = a; bus_size = sz;
        do @(negedge clk); while (!bus_ready);
        chk(bus_rdata == exp_d, {req, " data"}, bus_rdata, exp_d);
        chk((fs_cnt - fs0) == int'(exp_rs), {req, " restart R3 R4"}, fs_cnt - fs0, int'(exp_rs));
        if (exp_rs) chk(frame_addr == a, {req, " frame_addr R2"}, frame_addr, a);
        if (!mem_mode) chk((tot_acc - ac0) == n, {req, " R9 size"}, tot_acc - ac0, n);
        m_next = a + AW'(n);
        m_ptr  = m_ptr + AW'(n);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic pulse_last;
        @(negedge clk); last_xfer = 1'b1;
        @(negedge clk); last_xfer = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk({bus_ready, rx_ready, frame_start, frame_close, frame_done} == 5'b0, "R1 reset",
            {bus_ready, rx_ready, frame_start, frame_close, frame_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({bus_ready, rx_ready, frame_start, frame_close, frame_done} == 5'b0, "R1 after reset",
            {bus_ready, rx_ready, frame_start, frame_close, frame_done}, 0);

        // Directed memory-mode sequences
        do_read(16'h0100, 2'd2, "R2 R5 first word");
        do_read(16'h0104, 2'd0, "R3 R5 byte");
        do_read(16'h0105, 2'd1, "R3 R5 half");
        do_read(16'h0107, 2'd3, "R3 R5 code3 word");
        do_read(16'h0200, 2'd2, "R4 jump");
        repeat (30) @(negedge clk);
        chk(acc == 4 + DEPTH, "R7 prefetch depth", acc, 4 + DEPTH);
        chk(rx_ready == 1'b0, "R7 full stall", rx_ready, 0);
        do_read(16'h0300, 2'd1, "R4 discard buffered");

        // Stalled stream with last_xfer during pending read
        rx_en = 1'b0;
        fork
            do_read(16'h0400, 2'd2, "R11 pending read");
            begin
                int c0;
                bit saw;
                c0 = fc_cnt; saw = 1'b0;
                repeat (10) begin
                    @(negedge clk);
                    if (bus_ready) saw = 1'b1;
                end
                chk(!saw, "R6 no ready while stalled", saw, 0);
                pulse_last;
                @(negedge clk);
                chk(fc_cnt == c0 && !frame_done, "R11 last ignored", fc_cnt - c0, 0);
                rx_en = 1'b1;
            end
        join

        // Close while idle
        pulse_last;
        chk(frame_close && frame_done, "R10 close and done", {frame_close, frame_done}, 2'b11);
        m_open = 1'b0;
        repeat (2) @(negedge clk);
        chk(frame_done == 1'b1, "R10 done held", frame_done, 1);
        do_read(m_next, 2'd2, "R10 sequential after close");
        chk(frame_done == 1'b0, "R10 done cleared", frame_done, 0);

        // Random memory mode
        rx_prob = 60;
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic [1:0]    sz;
            sz = 2'($urandom % 4);
            a  = (($urandom % 100) < 70) ? m_next : AW'($urandom);
            do_read(a, sz, "R3 R4 R5 R6 random mem");
        end

        // Non-memory mode
        pulse_last;
        m_open = 1'b0;
        mem_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk(rx_ready == 1'b0, "R9 idle no rx", rx_ready, 0);
        do_read(16'h0040, 2'd0, "R8 first access");
        do_read(16'h7777, 2'd1, "R8 address ignored");
        for (int i = 0; i < 100; i++) begin
            do_read(AW'($urandom), 2'($urandom % 4), "R8 R9 random nonmem");
        end
        repeat (5) @(negedge clk);
        chk(rx_ready == 1'b0, "R9 idle no rx end", rx_ready, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule